// File: doc/BRIEF.md
# Multi-Width Serial Flash Phase Engine

This block lets software talk to a serial NAND flash one short phase at a time. A transaction (opcode, address, dummy cycles, data) is split into phases of one to four bytes. Each phase has its own lane width: one, two or four data lines. Software asserts a chip select through a control register, and the select stays asserted while it issues any number of phases. It then releases the select by writing all ones.

An outgoing phase needs two writes. The first goes to the transmit-setup register and gives the byte count and lane width. The second goes to the transmit-word register; the bytes are taken from the top of that word and shifting starts at once. An incoming phase needs one write, to the receive-setup register. The received bytes are then read back, left-aligned, from the receive-word register. A status register shows whether the engine is working and in which direction.

The serial clock is the system clock divided by two. It runs in SPI mode 0 and stays low between phases. The register bus is a simple single-cycle write and single-cycle read port, and read data is registered.

Top module: `sflash_pio`

## Requirements
- R1: After reset every chip select is high (released), `fl_sck` is low, `fl_io_oe` is 0 and the status register (offset 0x40) reads 0.
- R2: Chip-select control sits at offset 0x04. Output `fl_cs_n[n]` follows bit 4*n of that register, so a 0 selects device n. Writing 0xFFFFFFFF releases both selects. A select changes only when this register is written, and it holds across any number of phases.
- R3: Offset 0x08 (transmit setup) stores the byte count minus one in bits 1:0 and the lane code in bits 29:28. A later write to offset 0x14 (transmit word) shifts that many bytes out, starting at bit 31, most significant bit first.
- R4: Lane code 0 uses one line, 1 uses two lines, 2 uses four lines, and 3 behaves as code 0. The higher-numbered line carries the more significant bit. Single-line output is on line 0 and single-line input is on line 1. A phase has 8*bytes/lines serial clock pulses.
- R5: A write to offset 0x0C (receive setup) with count bits 1:0 and lane code bits 29:28 clocks in that many bytes. Offset 0x10 then returns them with the first byte in bits 31:24 and the unused low bytes as zero.
- R6: In the status register, bit 3 is set while a phase is running. Bit 2 is set during a receive phase and bit 1 during a transmit phase. All other bits read 0.
- R7: A write to offset 0x08, 0x0C or 0x14 while a phase runs is ignored. It neither starts a phase nor changes the stored transmit setup.
- R8: `fl_sck` is low whenever no phase runs. During a phase each high level lasts exactly one system clock, and inputs are sampled on the rising edge (SPI mode 0).
- R9: `fl_io_oe` enables exactly the lanes of a transmit phase, and only while that phase runs. It is 0 during receive phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| fl_sck | output | 1 | Serial clock to the flash |
| fl_cs_n | output | NUM_CS | Active-low chip selects |
| fl_io_o | output | 4 | Data lines driven out |
| fl_io_oe | output | 4 | Per-line output enable |
| fl_io_i | input | 4 | Data lines sampled in |

## Verification
A wrong pulse count or shift step in the phase engine shows up at the pins within one phase. The bench counts the serial clock pulses and rebuilds the byte stream from the lanes, so a miscount or a lane swap fails the very next phase. A stale busy flag or a lost transmit setup shows in the next status read, or as an extra or missing phase after a write that should have been ignored. A wrong receive alignment shows on the first read-back of a short receive.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;

  localparam logic [ADDR_W-1:0] OFF_CSEL = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_TSET = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RSET = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RWRD = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_TWRD = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h40;

  typedef enum logic [1:0] {
    LW_X1  = 2'd0,
    LW_X2  = 2'd1,
    LW_X4  = 2'd2,
    LW_RSV = 2'd3
  } lane_w_e;

  typedef struct packed {
    logic    is_rx;
    lane_w_e width;
    logic [1:0] len_m1;
  } phase_cfg_t;

  // log2 of bits moved per serial clock
  function automatic logic [1:0] lane_shift(lane_w_e w);
    case (w)
      LW_X2:   lane_shift = 2'd1;
      LW_X4:   lane_shift = 2'd2;
      default: lane_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/sfp_regs.sv
module sfp_regs
  import sfp_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int CS_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_rx,
  input  logic              eng_tx,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start,
  output phase_cfg_t        start_cfg,
  output logic [WORD_W-1:0] start_data,
  output logic [NUM_CS-1:0] cs_n
);
  logic [WORD_W-1:0] csel_q;
  logic [WORD_W-1:0] rwrd_q;
  phase_cfg_t        tset_q;
  logic              hit_tset, hit_rset, hit_twrd;

  assign hit_tset = reg_wr && (reg_addr == OFF_TSET) && !eng_busy;
  assign hit_rset = reg_wr && (reg_addr == OFF_RSET) && !eng_busy;
  assign hit_twrd = reg_wr && (reg_addr == OFF_TWRD) && !eng_busy;

  assign start      = hit_rset || hit_twrd;
  assign start_data = reg_wdata;

  always_comb begin
    if (hit_rset) begin
      start_cfg.is_rx  = 1'b1;
      start_cfg.width  = lane_w_e'(reg_wdata[29:28]);
      start_cfg.len_m1 = reg_wdata[1:0];
    end else begin
      start_cfg        = tset_q;
      start_cfg.is_rx  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q <= '1;
      tset_q <= '0;
      rwrd_q <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_CSEL)
        csel_q <= reg_wdata;
      if (hit_tset) begin
        tset_q.is_rx  <= 1'b0;
        tset_q.width  <= lane_w_e'(reg_wdata[29:28]);
        tset_q.len_m1 <= reg_wdata[1:0];
      end
      if (rx_valid)
        rwrd_q <= rx_word;
    end
  end

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign cs_n[n] = csel_q[CS_STRIDE*n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFF_CSEL: reg_rdata <= csel_q;
        OFF_TSET: reg_rdata <= {2'b00, tset_q.width, 26'd0, tset_q.len_m1};
        OFF_RWRD: reg_rdata <= rwrd_q;
        OFF_STAT: reg_rdata <= {28'd0, eng_busy, eng_rx, eng_tx, 1'b0};
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter
  import sfp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  phase_cfg_t        start_cfg,
  input  logic [WORD_W-1:0] start_data,
  input  logic [LANES-1:0]  in_bits,
  output logic              sck,
  output logic              busy,
  output logic              rx_act,
  output logic              tx_act,
  output lane_w_e           width,
  output logic [LANES-1:0]  tx_top,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  logic              is_rx;
  logic [1:0]        len_m1;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sreg;
  logic [WORD_W-1:0] rx_acc;
  logic [CNT_W-1:0]  bits_start;
  logic [CNT_W-1:0]  pulses_start;
  logic [WORD_W-1:0] rx_next;

  assign bits_start   = CNT_W'({3'(start_cfg.len_m1) + 3'd1, 3'b000});
  assign pulses_start = bits_start >> lane_shift(start_cfg.width);

  always_comb begin
    case (width)
      LW_X2:   rx_next = {rx_acc[WORD_W-3:0], in_bits[1:0]};
      LW_X4:   rx_next = {rx_acc[WORD_W-5:0], in_bits[3:0]};
      default: rx_next = {rx_acc[WORD_W-2:0], in_bits[0]};
    endcase
  end

  assign rx_act = busy && is_rx;
  assign tx_act = busy && !is_rx;
  assign tx_top = sreg[WORD_W-1 -: LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      is_rx    <= 1'b0;
      width    <= LW_X1;
      len_m1   <= '0;
      cnt      <= '0;
      sreg     <= '0;
      rx_acc   <= '0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        sck <= 1'b0;
        if (start) begin
          busy   <= 1'b1;
          is_rx  <= start_cfg.is_rx;
          width  <= start_cfg.width;
          len_m1 <= start_cfg.len_m1;
          cnt    <= pulses_start;
          sreg   <= start_data;
          rx_acc <= '0;
        end
      end else if (!sck) begin
        sck <= 1'b1;
        if (is_rx)
          rx_acc <= rx_next;
      end else begin
        sck  <= 1'b0;
        sreg <= sreg << (1 << lane_shift(width));
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          if (is_rx) begin
            rx_valid <= 1'b1;
            rx_word  <= rx_acc << {2'd3 - len_m1, 3'b000};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfp_lanes.sv
module sfp_lanes
  import sfp_pkg::*;
(
  input  lane_w_e          width,
  input  logic             tx_act,
  input  logic [LANES-1:0] tx_top,
  input  logic [LANES-1:0] io_i,
  output logic [LANES-1:0] io_o,
  output logic [LANES-1:0] io_oe,
  output logic [LANES-1:0] in_bits
);
  always_comb begin
    io_o  = '0;
    io_oe = '0;
    case (width)
      LW_X2: begin
        in_bits = {2'b00, io_i[1:0]};
        if (tx_act) begin
          io_o  = {2'b00, tx_top[3:2]};
          io_oe = 4'b0011;
        end
      end
      LW_X4: begin
        in_bits = io_i;
        if (tx_act) begin
          io_o  = tx_top;
          io_oe = 4'b1111;
        end
      end
      default: begin
        in_bits = {3'b000, io_i[1]};
        if (tx_act) begin
          io_o  = {3'b000, tx_top[3]};
          io_oe = 4'b0001;
        end
      end
    endcase
  end
endmodule

// File: rtl/sflash_pio.sv
module sflash_pio
  import sfp_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int CS_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fl_sck,
  output logic [NUM_CS-1:0] fl_cs_n,
  output logic [3:0]        fl_io_o,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_i
);
  logic              eng_busy, eng_rx, eng_tx, start, rx_valid;
  phase_cfg_t        start_cfg;
  logic [WORD_W-1:0] start_data, rx_word;
  lane_w_e           width;
  logic [LANES-1:0]  tx_top, in_bits;

  sfp_regs #(.NUM_CS(NUM_CS), .CS_STRIDE(CS_STRIDE)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_rx(eng_rx), .eng_tx(eng_tx),
    .rx_valid(rx_valid), .rx_word(rx_word), .start(start),
    .start_cfg(start_cfg), .start_data(start_data), .cs_n(fl_cs_n)
  );

  sfp_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .start_cfg(start_cfg),
    .start_data(start_data), .in_bits(in_bits), .sck(fl_sck),
    .busy(eng_busy), .rx_act(eng_rx), .tx_act(eng_tx), .width(width),
    .tx_top(tx_top), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  sfp_lanes u_lanes (
    .width(width), .tx_act(eng_tx), .tx_top(tx_top), .io_i(fl_io_i),
    .io_o(fl_io_o), .io_oe(fl_io_oe), .in_bits(in_bits)
  );
endmodule

// File: rtl/sfp_chk.sv
module sfp_chk
  import sfp_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic              fl_sck,
  input logic [NUM_CS-1:0] fl_cs_n,
  input logic [3:0]        fl_io_oe,
  input logic              eng_busy,
  input logic              eng_rx,
  input logic              eng_tx
);
  // R8
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !fl_sck);
  // R8
  sck_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fl_sck |=> !fl_sck);
  // R9
  oe_quiet_rx_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rx |-> fl_io_oe == 4'b0000);
  // R9
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_tx |-> fl_io_oe == 4'b0000);
  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    fl_io_oe inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});
  // R6
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eng_rx, eng_tx}));
  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == OFF_CSEL) |=> $stable(fl_cs_n));
endmodule

bind sflash_pio sfp_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_io_oe(fl_io_oe),
  .eng_busy(eng_busy), .eng_rx(eng_rx), .eng_tx(eng_tx)
);

// File: tb/sflash_pio_bench.sv
module sflash_pio_bench;
  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fl_sck;
  logic [1:0]  fl_cs_n;
  logic [3:0]  fl_io_o, fl_io_oe, fl_io_i;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sflash_pio u_sflash_pio (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fl_sck(fl_sck), .fl_cs_n(fl_cs_n), .fl_io_o(fl_io_o),
    .fl_io_oe(fl_io_oe), .fl_io_i(fl_io_i)
  );

  // flash model
  logic [31:0] mdl_tx = 0;
  logic [1:0]  mdl_w = 0;
  logic        mdl_rx = 0;
  logic [31:0] cap = 0;
  int          cap_bits = 0, rises = 0, oe_in_rx = 0;

  always_comb begin
    case (mdl_w)
      2'd1:    fl_io_i = {2'b00, mdl_tx[31:30]};
      2'd2:    fl_io_i = mdl_tx[31:28];
      default: fl_io_i = {2'b00, mdl_tx[31], 1'b0};
    endcase
  end

  always @(posedge fl_sck) begin
    rises = rises + 1;
    if (mdl_rx && fl_io_oe != 0) oe_in_rx = oe_in_rx + 1;
    case (fl_io_oe)
      4'b0001: begin cap = {cap[30:0], fl_io_o[0]};   cap_bits = cap_bits + 1; end
      4'b0011: begin cap = {cap[29:0], fl_io_o[1:0]}; cap_bits = cap_bits + 2; end
      4'b1111: begin cap = {cap[27:0], fl_io_o};      cap_bits = cap_bits + 4; end
      default: ;
    endcase
  end

  always @(negedge fl_sck) begin
    if (mdl_rx) begin
      case (mdl_w)
        2'd1:    mdl_tx = mdl_tx << 2;
        2'd2:    mdl_tx = mdl_tx << 4;
        default: mdl_tx = mdl_tx << 1;
      endcase
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_rd(8'h40, s);
      if (!s[3]) return;
    end
    check("R6 stuck busy", s, 32'h0);
  endtask

  task automatic clr_mon();
    cap = 0; cap_bits = 0; rises = 0; oe_in_rx = 0;
  endtask

  function automatic int lanes(logic [1:0] w);
    return (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
  endfunction

  // {is_rx, lane code, len-1, data}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 32'hA500_0000},
    {1'b0, 2'd0, 2'd3, 32'h135A_C37E},
    {1'b0, 2'd1, 2'd2, 32'h3C96_F1FF},
    {1'b0, 2'd2, 2'd1, 32'hE718_5555},
    {1'b1, 2'd0, 2'd3, 32'hC936_5AA5},
    {1'b1, 2'd1, 2'd1, 32'hB44B_1234},
    {1'b1, 2'd2, 2'd2, 32'h7D82_E19F},
    {1'b1, 2'd0, 2'd0, 32'h6E00_FFFF}
  };

  initial begin : wd
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, s1, s2, mask;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 cs_n", {30'd0, fl_cs_n}, 32'h3);
    check("R1 sck", {31'd0, fl_sck}, 0);
    check("R1 oe", {28'd0, fl_io_oe}, 0);
    bus_rd(8'h40, r); check("R1 status", r, 0);

    // R2 select device 0 and device 1
    bus_wr(8'h04, 32'hFFFF_FFFE);
    check("R2 cs0 low", {30'd0, fl_cs_n}, 32'h2);
    bus_wr(8'h04, 32'hFFFF_FFEF);
    check("R2 cs1 low", {30'd0, fl_cs_n}, 32'h1);
    bus_wr(8'h04, 32'hFFFF_FFFE);

    // vector table: R3 R4 R5
    foreach (VEC[i]) begin
      logic        isrx;
      logic [1:0]  w, lm;
      logic [31:0] d;
      int          nb;
      {isrx, w, lm, d} = VEC[i];
      nb = lm + 1;
      mask = 32'hFFFF_FFFF << (32 - 8*nb);
      clr_mon();
      if (isrx) begin
        mdl_tx = d; mdl_w = w; mdl_rx = 1;
        bus_wr(8'h0C, {2'b00, w, 26'd0, lm});
        wait_idle();
        mdl_rx = 0;
        bus_rd(8'h10, r);
        check("R5 rx word", r, d & mask);
        check("R9 oe in rx", oe_in_rx, 0);
      end else begin
        mdl_w = 0;
        bus_wr(8'h08, {2'b00, w, 26'd0, lm});
        bus_wr(8'h14, d);
        wait_idle();
        check("R3 tx bytes", cap, d >> (32 - 8*nb));
        check("R3 tx bits", cap_bits, 8*nb);
      end
      check("R4 pulses", rises, (8*nb) / lanes(w));
      check("R2 cs held", {30'd0, fl_cs_n}, 32'h2);
      check("R8 sck idle", {31'd0, fl_sck}, 0);
    end

    // R6 status during transmit and receive
    bus_wr(8'h08, 32'h0000_0003);
    bus_wr(8'h14, 32'h1234_5678);
    bus_rd(8'h40, s1);
    check("R6 tx status", s1, 32'h0000_000A);
    wait_idle();
    mdl_w = 0; mdl_rx = 1; mdl_tx = 0;
    bus_wr(8'h0C, 32'h0000_0003);
    bus_rd(8'h40, s2);
    check("R6 rx status", s2, 32'h0000_000C);
    wait_idle(); mdl_rx = 0;

    // R7 writes during a phase are ignored
    clr_mon();
    bus_wr(8'h08, 32'h0000_0000);
    bus_wr(8'h14, 32'h8100_0000);
    bus_wr(8'h08, 32'h2000_0003);
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_wr(8'h0C, 32'h1000_0003);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R7 one phase only", rises, 8);
    check("R7 data kept", cap, 32'h81);
    clr_mon();
    bus_wr(8'h14, 32'h4200_0000);
    wait_idle();
    check("R7 setup kept", rises, 8);
    check("R7 setup kept data", cap, 32'h42);
    bus_rd(8'h08, r);
    check("R7 setup readback", r, 32'h0);

    // R4 reserved lane code behaves as single
    clr_mon();
    bus_wr(8'h08, 32'h3000_0000);
    bus_wr(8'h14, 32'h9900_0000);
    wait_idle();
    check("R4 code3 pulses", rises, 8);
    check("R4 code3 data", cap, 32'h99);

    // R8 sck low after all activity; R2 release
    check("R8 sck idle end", {31'd0, fl_sck}, 0);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    check("R2 release", {30'd0, fl_cs_n}, 32'h3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule